// File: doc/BRIEF.md
# Keyed-sequence watchdog timer

This block is a register-mapped watchdog. A 32-bit up-counter advances on strobes from a slow 32.768 kHz time base, either on every strobe or, through a prescaler, once every 2^p strobes. When the counter steps past its all-ones value, the block raises a one-cycle reset pulse and refills the counter from a load register. Software keeps the system alive by writing a new value into a trigger register. A value that differs from the one already held copies the load value into the counter.

The timer cannot be started or halted by one stray store. Each needs two key words, written in order to the key register. Writes to the control, counter, load, trigger and key registers are posted. A crossing into the slow domain is modelled as a fixed delay of `POST_DLY` system clocks. A status register shows, per register, which writes have not yet landed, and drivers poll it before the next dependent access. A timeout of N seconds at prescale 1 is obtained with the load value 2^32 − N·32768.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, the control, counter, load, trigger and pending-status registers read 0, the timer is halted and `wdt_rst_o` is low.
- R2: Offset 0x00 reads the revision, with `REV_MAJOR` in bits 7:4, `REV_MINOR` in bits 3:0 and zero above.
- R3: The key register (offset 0x48) receives 0x0000BBBB and then 0x00004444 as consecutive landed writes. The timer then runs.
- R4: The key register receives 0x0000AAAA and then 0x00005555 as consecutive landed writes. The timer then halts, and the counter holds its value across strobes.
- R5: A first key word followed by any word other than its own second word returns the key sequencer to idle. The run state is left unchanged, so a later lone second word has no effect.
- R6: A write sets its pending bit in the status register (offset 0x34) at once: bit 4 key, bit 3 trigger, bit 2 load, bit 1 counter, bit 0 control. The written register keeps its old value while the bit is set. The bit clears, and the new value lands, exactly `POST_DLY` clocks after the write edge.
- R7: Control (offset 0x24) bit 5 enables the prescaler and bits 4:2 hold p. With bit 5 set, the counter advances once every 2^p strobes. With bit 5 clear, it advances on every strobe whatever p is.
- R8: The counter (offset 0x28) advances by one only on `tick_i` strobes while running. While halted, strobes do not change it.
- R9: A landed trigger write (offset 0x30) whose value differs from the stored trigger copies the load register (offset 0x2C) into the counter. Writing the same value leaves the counter unchanged.
- R10: When the counter advances from 0xFFFFFFFF, `wdt_rst_o` is high for exactly one clock and the counter becomes the load value.
- R11: A counter loaded directly with 0xFFFFFF80 and then started produces the reset pulse on the 128th strobe and not before.
- R12: Control reads its 6 stored bits, trigger and load read their stored values, and the key register and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe from the 32.768 kHz time base |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wdt_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
The assertions expect `tick_i` to be a single-cycle strobe. They also expect reset to be held across the first clock edges, so the past values they compare are defined. The stimulus drives `tick_i` high for one clock with a low clock between strobes. It polls the pending-status register after each write that later steps depend on, so key words, trigger values and counter loads land in a known order. Only the posting test deliberately samples while a write is still in flight. There it counts the clocks to the exact landing edge.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;

  localparam int NUM_CH = 5;

  // posting channels; index equals pending-status bit position
  localparam int CH_CTRL  = 0;
  localparam int CH_COUNT = 1;
  localparam int CH_LOAD  = 2;
  localparam int CH_TRIG  = 3;
  localparam int CH_KEY   = 4;

  localparam logic [7:0] OFS_IDENT = 8'h00;
  localparam logic [7:0] OFS_CTRL  = 8'h24;
  localparam logic [7:0] OFS_COUNT = 8'h28;
  localparam logic [7:0] OFS_LOAD  = 8'h2C;
  localparam logic [7:0] OFS_TRIG  = 8'h30;
  localparam logic [7:0] OFS_PEND  = 8'h34;
  localparam logic [7:0] OFS_KEY   = 8'h48;

  localparam logic [31:0] KEY_RUN_A  = 32'h0000_BBBB;
  localparam logic [31:0] KEY_RUN_B  = 32'h0000_4444;
  localparam logic [31:0] KEY_HALT_A = 32'h0000_AAAA;
  localparam logic [31:0] KEY_HALT_B = 32'h0000_5555;

  typedef enum logic [1:0] {
    KS_IDLE       = 2'd0,
    KS_RUN_ARMED  = 2'd1,
    KS_HALT_ARMED = 2'd2
  } key_state_e;

  // one-hot posting channel hit for a write offset
  function automatic logic [NUM_CH-1:0] wr_decode(input logic [7:0] a);
    logic [NUM_CH-1:0] v;
    v = '0;
    case (a)
      OFS_CTRL:  v[CH_CTRL]  = 1'b1;
      OFS_COUNT: v[CH_COUNT] = 1'b1;
      OFS_LOAD:  v[CH_LOAD]  = 1'b1;
      OFS_TRIG:  v[CH_TRIG]  = 1'b1;
      OFS_KEY:   v[CH_KEY]   = 1'b1;
      default:   v = '0;
    endcase
    return v;
  endfunction

  // strobes per counter step
  function automatic logic [7:0] presc_span(input logic en, input logic [2:0] sel);
    return en ? (8'd1 << sel) : 8'd1;
  endfunction

  // load value giving a timeout of the given number of counter steps
  function automatic logic [31:0] timeout_load(input logic [31:0] steps);
    return 32'h0 - steps;
  endfunction

endpackage

// File: rtl/wdt_post_track.sv
module wdt_post_track #(
  parameter int NUM_CH   = 5,
  parameter int POST_DLY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] wr_vec,
  output logic [NUM_CH-1:0] pend,
  output logic [NUM_CH-1:0] commit
);
  localparam int DW = $clog2(POST_DLY + 1);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [DW-1:0] dly_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dly_q <= '0;
      end else if (wr_vec[i]) begin
        dly_q <= DW'(POST_DLY);
      end else if (dly_q != '0) begin
        dly_q <= dly_q - DW'(1);
      end
    end

    assign pend[i]   = (dly_q != '0);
    // a rewrite in the landing cycle restarts the delay instead
    assign commit[i] = (dly_q == DW'(1)) && !wr_vec[i];
  end

endmodule

// File: rtl/wdt_key_fsm.sv
module wdt_key_fsm
  import wdt_keyed_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_valid,
  input  logic [31:0] key_word,
  output logic        running,
  output logic        start_evt,
  output logic        stop_evt
);
  key_state_e st_q, st_d;
  logic       run_q;

  assign start_evt = key_valid && (st_q == KS_RUN_ARMED)  && (key_word == KEY_RUN_B);
  assign stop_evt  = key_valid && (st_q == KS_HALT_ARMED) && (key_word == KEY_HALT_B);

  always_comb begin
    st_d = st_q;
    if (key_valid) begin
      if (st_q == KS_IDLE) begin
        if (key_word == KEY_RUN_A)       st_d = KS_RUN_ARMED;
        else if (key_word == KEY_HALT_A) st_d = KS_HALT_ARMED;
        else                             st_d = KS_IDLE;
      end else begin
        // second word, right or wrong, ends the sequence
        st_d = KS_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= KS_IDLE;
      run_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (start_evt)     run_q <= 1'b1;
      else if (stop_evt) run_q <= 1'b0;
    end
  end

  assign running = run_q;

endmodule

// File: rtl/wdt_count_core.sv
module wdt_count_core
  import wdt_keyed_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          running,
  input  logic          presc_en,
  input  logic [2:0]    presc_sel,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wr_val,
  input  logic          reload,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          adv_evt,
  output logic          ovf_evt,
  output logic          rst_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [7:0]    pcnt_q;
  logic [7:0]    span;
  logic [CW-1:0] cnt_q;
  logic          rst_q;
  logic          wrap;

  assign span    = presc_span(presc_en, presc_sel);
  assign adv_evt = running && tick_i && (pcnt_q == span - 8'd1);
  assign wrap    = adv_evt && (cnt_q == CNT_MAX);
  assign ovf_evt = wrap && !cnt_wr && !reload;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else if (!running) begin
      pcnt_q <= '0;
    end else if (tick_i) begin
      pcnt_q <= adv_evt ? 8'd0 : pcnt_q + 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else begin
      rst_q <= ovf_evt;
      if (cnt_wr)       cnt_q <= cnt_wr_val;
      else if (reload)  cnt_q <= load_val;
      else if (wrap)    cnt_q <= load_val;
      else if (adv_evt) cnt_q <= cnt_q + CW'(1);
    end
  end

  assign cnt   = cnt_q;
  assign rst_o = rst_q;

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_keyed_pkg::*;
#(
  parameter int         POST_DLY  = 4,
  parameter logic [3:0] REV_MAJOR = 4'h2,
  parameter logic [3:0] REV_MINOR = 4'h1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wdt_rst_o
);
  localparam int CW = 32;

  logic [NUM_CH-1:0] wr_vec, pend, commit;
  logic [31:0]       shadow [NUM_CH];
  logic [5:0]        ctrl_q;
  logic [CW-1:0]     load_q, trig_q, cnt;
  logic              running, start_evt, stop_evt;
  logic              adv_evt, ovf_evt;
  logic              cnt_wr_commit, reload_evt;

  assign wr_vec = bus_wr ? wr_decode(bus_addr) : '0;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (!rst_n)         shadow[i] <= '0;
      else if (wr_vec[i]) shadow[i] <= bus_wdata;
    end
  end

  wdt_post_track #(.NUM_CH(NUM_CH), .POST_DLY(POST_DLY)) u_post (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_vec (wr_vec),
    .pend   (pend),
    .commit (commit)
  );

  assign cnt_wr_commit = commit[CH_COUNT];
  assign reload_evt    = commit[CH_TRIG] && (shadow[CH_TRIG] != trig_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
      trig_q <= '0;
    end else begin
      if (commit[CH_CTRL]) ctrl_q <= shadow[CH_CTRL][5:0];
      if (commit[CH_LOAD]) load_q <= shadow[CH_LOAD];
      if (commit[CH_TRIG]) trig_q <= shadow[CH_TRIG];
    end
  end

  wdt_key_fsm u_key (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_valid (commit[CH_KEY]),
    .key_word  (shadow[CH_KEY]),
    .running   (running),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  wdt_count_core #(.CW(CW)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .running    (running),
    .presc_en   (ctrl_q[5]),
    .presc_sel  (ctrl_q[4:2]),
    .cnt_wr     (cnt_wr_commit),
    .cnt_wr_val (shadow[CH_COUNT]),
    .reload     (reload_evt),
    .load_val   (load_q),
    .cnt        (cnt),
    .adv_evt    (adv_evt),
    .ovf_evt    (ovf_evt),
    .rst_o      (wdt_rst_o)
  );

  always_comb begin
    case (bus_addr)
      OFS_IDENT: bus_rdata = {24'h0, REV_MAJOR, REV_MINOR};
      OFS_CTRL:  bus_rdata = {26'h0, ctrl_q};
      OFS_COUNT: bus_rdata = cnt;
      OFS_LOAD:  bus_rdata = load_q;
      OFS_TRIG:  bus_rdata = trig_q;
      OFS_PEND:  bus_rdata = {{(32-NUM_CH){1'b0}}, pend};
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
  parameter int CW     = 32,
  parameter int NUM_CH = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              running,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              adv_evt,
  input logic              cnt_wr_commit,
  input logic              reload_evt,
  input logic [CW-1:0]     cnt,
  input logic [CW-1:0]     load_q,
  input logic              rst_o,
  input logic [NUM_CH-1:0] wr_vec,
  input logic [NUM_CH-1:0] pend,
  input logic [NUM_CH-1:0] commit
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  // R10: pulse lasts one clock
  a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rst_o |=> !rst_o);

  // R10: counter refilled from load at the pulse
  a_r10_refill: assert property (@(posedge clk) disable iff (!rst_n)
    rst_o |-> (cnt == $past(load_q)));

  // R10: advance from all ones raises the pulse
  a_r10_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && cnt == CNT_MAX && !cnt_wr_commit && !reload_evt) |=> rst_o);

  // R8: plain advance steps by one
  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && cnt != CNT_MAX && !cnt_wr_commit && !reload_evt)
      |=> (cnt == $past(cnt) + CW'(1)));

  // R4 / R8: halted counter holds unless written or reloaded
  a_r8_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !cnt_wr_commit && !reload_evt) |=> $stable(cnt));

  // R5: run state moves only on a completed key pair
  a_r5_run_change: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(running) |-> $past(start_evt || stop_evt));

  // R3: completed start pair leaves the timer running
  a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> running);

  // R6: landed channel clears its pending bit
  a_r6_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (commit != '0 && wr_vec == '0) |=> ((pend & $past(commit)) == '0));

  // R6: a write marks its channel pending
  a_r6_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vec != '0) |=> ((pend & $past(wr_vec)) == $past(wr_vec)));

endmodule

bind wdt_keyed wdt_keyed_chk #(.CW(CW), .NUM_CH(wdt_keyed_pkg::NUM_CH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .running       (running),
  .start_evt     (start_evt),
  .stop_evt      (stop_evt),
  .adv_evt       (adv_evt),
  .cnt_wr_commit (cnt_wr_commit),
  .reload_evt    (reload_evt),
  .cnt           (cnt),
  .load_q        (load_q),
  .rst_o         (wdt_rst_o),
  .wr_vec        (wr_vec),
  .pend          (pend),
  .commit        (commit)
);

// File: tb/tb_wdt_keyed.sv
module tb_wdt_keyed;
  localparam int POST_DLY = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        wdt_rst_o;

  int n_checks = 0;
  int n_fail   = 0;
  int pulses   = 0;
  int run_len  = 0;
  int max_run  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  wdt_keyed #(.POST_DLY(POST_DLY), .REV_MAJOR(4'h2), .REV_MINOR(4'h1)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .wdt_rst_o (wdt_rst_o)
  );

  // pulse monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (wdt_rst_o) begin
      if (run_len == 0) pulses++;
      run_len++;
      if (run_len > max_run) max_run = run_len;
    end else begin
      run_len = 0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic sync_wait();
    logic [31:0] s;
    rd(8'h34, s);
    while (s != 32'h0) begin
      @(negedge clk);
      rd(8'h34, s);
    end
  endtask

  task automatic wr_sync(input logic [7:0] a, input logic [31:0] d);
    wr(a, d);
    sync_wait();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  function automatic logic [31:0] exp_ctrl(input bit en, input int p);
    return {26'h0, en, 3'(p), 2'b00};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); check("R2 ident", v, 32'h0000_0021);
    rd(8'h24, v); check("R1 ctrl", v, 32'h0);
    rd(8'h28, v); check("R1 count", v, 32'h0);
    rd(8'h2C, v); check("R1 load", v, 32'h0);
    rd(8'h30, v); check("R1 trig", v, 32'h0);
    rd(8'h34, v); check("R1 pend", v, 32'h0);
    check("R1 rst out", {31'h0, wdt_rst_o}, 32'h0);
    ticks(3);
    rd(8'h28, v); check("R1 halted after reset", v, 32'h0);
  endtask

  task automatic t_posting();
    logic [31:0] v;
    wr(8'h2C, 32'h55);
    rd(8'h34, v); check("R6 load pending bit2", v, 32'h4);
    rd(8'h2C, v); check("R6 load old value", v, 32'h0);
    repeat (POST_DLY - 1) @(negedge clk);
    rd(8'h34, v); check("R6 still pending before landing", v, 32'h4);
    @(negedge clk);
    rd(8'h34, v); check("R6 pending cleared", v, 32'h0);
    rd(8'h2C, v); check("R6 load landed", v, 32'h55);
    wr(8'h48, 32'h0);
    rd(8'h34, v); check("R6 key pending bit4", v, 32'h10);
    sync_wait();
    wr(8'h24, 32'h0);
    rd(8'h34, v); check("R6 ctrl pending bit0", v, 32'h1);
    sync_wait();
  endtask

  task automatic t_keys();
    logic [31:0] v;
    wr_sync(8'h48, 32'hBBBB);
    wr_sync(8'h48, 32'h1234);
    wr_sync(8'h48, 32'h4444);
    ticks(3);
    rd(8'h28, v); check("R5 wrong second word leaves halted", v, 32'h0);
    wr_sync(8'h48, 32'hBBBB);
    wr_sync(8'h48, 32'h4444);
    ticks(5);
    rd(8'h28, v); check("R3 R8 running counts strobes", v, 32'h5);
    wr_sync(8'h48, 32'hAAAA);
    wr_sync(8'h48, 32'hBBBB);
    wr_sync(8'h48, 32'h5555);
    ticks(2);
    rd(8'h28, v); check("R5 interrupted stop keeps running", v, 32'h7);
    wr_sync(8'h48, 32'hAAAA);
    wr_sync(8'h48, 32'h5555);
    ticks(4);
    rd(8'h28, v); check("R4 halted counter holds", v, 32'h7);
  endtask

  task automatic t_presc();
    logic [31:0] v;
    wr_sync(8'h24, exp_ctrl(1'b1, 2));
    rd(8'h24, v); check("R12 ctrl readback", v, 32'h28);
    wr_sync(8'h28, 32'h0);
    wr_sync(8'h48, 32'hBBBB);
    wr_sync(8'h48, 32'h4444);
    ticks(8);
    rd(8'h28, v); check("R7 prescale 4 after 8 strobes", v, 32'h2);
    ticks(3);
    rd(8'h28, v); check("R7 partial span no step", v, 32'h2);
    wr_sync(8'h48, 32'hAAAA);
    wr_sync(8'h48, 32'h5555);
    wr_sync(8'h24, exp_ctrl(1'b0, 2));
    wr_sync(8'h28, 32'h0);
    wr_sync(8'h48, 32'hBBBB);
    wr_sync(8'h48, 32'h4444);
    ticks(3);
    rd(8'h28, v); check("R7 prescaler off counts every strobe", v, 32'h3);
    wr_sync(8'h48, 32'hAAAA);
    wr_sync(8'h48, 32'h5555);
    wr_sync(8'h24, 32'h0);
  endtask

  task automatic t_trigger();
    logic [31:0] v;
    wr_sync(8'h2C, 32'h100);
    wr_sync(8'h30, 32'h1);
    rd(8'h28, v); check("R9 new trigger reloads", v, 32'h100);
    wr_sync(8'h28, 32'h5);
    wr_sync(8'h30, 32'h1);
    rd(8'h28, v); check("R9 same trigger no reload", v, 32'h5);
    wr_sync(8'h30, 32'h2);
    rd(8'h28, v); check("R9 changed trigger reloads", v, 32'h100);
    rd(8'h30, v); check("R12 trig readback", v, 32'h2);
    rd(8'h48, v); check("R12 key reads zero", v, 32'h0);
    rd(8'h04, v); check("R12 unmapped reads zero", v, 32'h0);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    wr_sync(8'h2C, 32'h10);
    wr_sync(8'h28, 32'hFFFF_FF80);
    wr_sync(8'h48, 32'hBBBB);
    wr_sync(8'h48, 32'h4444);
    pulses = 0; max_run = 0;
    ticks(127);
    check("R11 no pulse before 128th strobe", pulses, 0);
    rd(8'h28, v); check("R11 count at all ones", v, 32'hFFFF_FFFF);
    ticks(1);
    @(negedge clk);
    check("R11 pulse on 128th strobe", pulses, 1);
    check("R10 pulse one clock wide", max_run, 1);
    rd(8'h28, v); check("R10 counter refilled from load", v, 32'h10);
    ticks(1);
    rd(8'h28, v); check("R10 counting resumes from load", v, 32'h11);
    wr_sync(8'h48, 32'hAAAA);
    wr_sync(8'h48, 32'h5555);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_posting();
    t_keys();
    t_presc();
    t_trigger();
    t_overflow();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule